// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the sampled levels of a small group of general-purpose pins into interrupt status. Each pin has a three-bit trigger field that picks one of five sensing modes: high level, low level, rising edge, falling edge, or either edge. A qualifying event sets that pin's status bit. The bit stays set until software clears it with a write-one-to-clear strobe. The block drives a single interrupt line for the whole group. That line is high whenever a pin has both its status bit and its enable bit set.

The pins arrive already synchronized, and the configuration, enable and clear vectors come from a neighbouring register block. This block owns only the detection, the sticky status and the output gating. Edge detection compares each pin with its own sample from the previous cycle. A new event on a pin takes priority over a clear of that pin in the same cycle. Because of that priority, an edge that arrives while software acknowledges the previous one is kept rather than lost.

Top module: `gpio_irq_detector`

## Requirements
- R1: For pin n of NUM_PINS (default 8), the trigger field is made of three bits. The polarity bit is trig_cfg_i[n], the edge-select bit is trig_cfg_i[NUM_PINS+n] and the both-edges bit is trig_cfg_i[2*NUM_PINS+n]. Written as {both, edge, polarity}, the codes are: 000 low level, 001 high level, 011 rising edge, 010 falling edge, 110 either edge. When edge is 0 the both bit is ignored. When both and edge are 1 the polarity bit is ignored.
- R2: In a level mode, a pin sampled at its active level sets its status bit, which is visible on status_o after the next rising clock edge. While the level persists, the bit is set again on every cycle, so a clear cannot remove it.
- R3: In rising mode, status is set when the pin is sampled 1 and its sample from the previous cycle was 0. In falling mode the condition is the reverse. Either way, status_o shows the bit one clock later.
- R4: In either-edge mode, any change of the pin between two consecutive samples sets status.
- R5: No edge is reported for the first sampled cycle after reset is released, whatever the pin did across that boundary.
- R6: clr_i[n] high for one cycle clears status bit n at the next clock edge. A 0 in clr_i leaves the corresponding bit unchanged.
- R7: If a qualifying event and a clear hit the same pin in the same cycle, the event wins and the bit stays set.
- R8: Status bits latch whether or not the pin is enabled. irq_o is the OR over all pins of status AND irq_en_i, and it follows irq_en_i in the same cycle.
- R9: A set status bit stays set after its event has gone away, until it is cleared.
- R10: Synchronous active-high reset clears every status bit, which drives irq_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| trig_cfg_i | input | 3*NUM_PINS | Per-pin trigger fields (polarity, edge, both lanes) |
| irq_en_i | input | NUM_PINS | Per-pin interrupt enable |
| clr_i | input | NUM_PINS | Write-one-to-clear strobes for status |
| status_o | output | NUM_PINS | Sticky per-pin interrupt status |
| irq_o | output | 1 | Group interrupt line |

## Verification
Two things can land on one pin in the same cycle: the acknowledge strobe and a new qualifying event, whether an edge or a still-active level. The bench drives a clear at the exact cycle in which a rising edge is sampled. It also holds a high level under repeated clears. In both cases it expects the status bit to remain set. A long random stretch applies sparse clears alongside random pin activity and mixed modes. A cycle-accurate behavioural model judges every cycle and flags any cycle in which the clear wrongly beats the event.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Decoded sensing mode of one pin
    typedef enum logic [2:0] {
        MODE_LVL_LOW  = 3'd0,
        MODE_LVL_HIGH = 3'd1,
        MODE_RISE     = 3'd2,
        MODE_FALL     = 3'd3,
        MODE_BOTH     = 3'd4
    } trig_mode_e;

    // Raw three-bit trigger field of one pin, gathered from three lanes
    typedef struct packed {
        logic both_sel;
        logic edge_sel;
        logic pol_sel;
    } trig_field_t;

    function automatic trig_mode_e decode_trig(input trig_field_t f);
        trig_mode_e m;
        if (!f.edge_sel)
            m = f.pol_sel ? MODE_LVL_HIGH : MODE_LVL_LOW;
        else if (f.both_sel)
            m = MODE_BOTH;
        else
            m = f.pol_sel ? MODE_RISE : MODE_FALL;
        return m;
    endfunction

    function automatic logic is_edge_mode(input trig_mode_e m);
        return (m == MODE_RISE) || (m == MODE_FALL) || (m == MODE_BOTH);
    endfunction

    // Qualifying event for one pin given the current and previous sample
    function automatic logic qualify(input trig_mode_e m, input logic cur,
                                     input logic prv, input logic hist_ok);
        logic ev;
        case (m)
            MODE_LVL_LOW:  ev = ~cur;
            MODE_LVL_HIGH: ev = cur;
            MODE_RISE:     ev = hist_ok & cur & ~prv;
            MODE_FALL:     ev = hist_ok & ~cur & prv;
            MODE_BOTH:     ev = hist_ok & (cur ^ prv);
            default:       ev = 1'b0;
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/gpio_irq_pin_detect.sv
module gpio_irq_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_i,
    input  logic        hist_ok_i,
    input  trig_field_t field_i,
    output trig_mode_e  mode_o,
    output logic        event_o
);

    logic prev_q;

    // Previous sample, captured every cycle including during reset
    always_ff @(posedge clk) begin
        prev_q <= pin_i;
    end

    always_comb begin
        mode_o  = decode_trig(field_i);
        event_o = qualify(mode_o, pin_i, prev_q, hist_ok_i);
    end

    // R5: first cycle after reset release never yields an edge event
    p_quiet_after_reset_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && is_edge_mode(mode_o)) |-> !event_o)
        else $error("edge event in first cycle after reset");

    // R3: a sampled 0 -> 1 transition in rising mode must qualify
    p_rise_seen_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode_o == MODE_RISE && pin_i && !$past(pin_i)) |-> event_o)
        else $error("rising edge missed");

    // R4: any change in either-edge mode must qualify
    p_both_seen_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode_o == MODE_BOTH && (pin_i != $past(pin_i))) |-> event_o)
        else $error("edge missed in either-edge mode");

endmodule

// File: rtl/gpio_irq_status_bit.sv
module gpio_irq_status_bit (
    input  logic clk,
    input  logic rst,
    input  logic event_i,
    input  logic clr_i,
    output logic status_o
);

    logic status_q;

    // Event has priority over the acknowledge strobe
    always_ff @(posedge clk) begin
        if (rst)
            status_q <= 1'b0;
        else
            status_q <= event_i | (status_q & ~clr_i);
    end

    assign status_o = status_q;

    // R7: an event always leaves the bit set, even under a clear
    p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
        event_i |=> status_o)
        else $error("event lost");

    // R6: a clear with no event empties the bit
    p_clear_takes_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !event_i) |=> !status_o)
        else $error("clear ignored");

    // R9: no clear, bit holds
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (status_o && !clr_i) |=> status_o)
        else $error("status dropped without clear");

endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic [3*NUM_PINS-1:0] trig_cfg_i,
    input  logic [NUM_PINS-1:0]   irq_en_i,
    input  logic [NUM_PINS-1:0]   clr_i,
    output logic [NUM_PINS-1:0]   status_o,
    output logic                  irq_o
);

    localparam int EDGE_LANE = NUM_PINS;
    localparam int BOTH_LANE = 2 * NUM_PINS;

    logic                hist_q;
    logic [NUM_PINS-1:0] evt;

    // Previous samples become valid one cycle after reset release
    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= 1'b0;
        else
            hist_q <= 1'b1;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        trig_field_t fld;
        trig_mode_e  mode;

        assign fld.pol_sel  = trig_cfg_i[g];
        assign fld.edge_sel = trig_cfg_i[EDGE_LANE + g];
        assign fld.both_sel = trig_cfg_i[BOTH_LANE + g];

        gpio_irq_pin_detect i_det (
            .clk       (clk),
            .rst       (rst),
            .pin_i     (pin_i[g]),
            .hist_ok_i (hist_q),
            .field_i   (fld),
            .mode_o    (mode),
            .event_o   (evt[g])
        );

        gpio_irq_status_bit i_stat (
            .clk      (clk),
            .rst      (rst),
            .event_i  (evt[g]),
            .clr_i    (clr_i[g]),
            .status_o (status_o[g])
        );

        // R2: active high level sets the bit next cycle, clear or not
        p_level_high_r2: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_LVL_HIGH && pin_i[g]) |=> status_o[g])
            else $error("high level not latched");

        // R2: active low level likewise
        p_level_low_r2: assert property (@(posedge clk) disable iff (rst)
            (mode == MODE_LVL_LOW && !pin_i[g]) |=> status_o[g])
            else $error("low level not latched");
    end

    assign irq_o = |(status_o & irq_en_i);

    // R8: the line is never raised without some enable set
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (irq_en_i != '0))
        else $error("irq raised with all enables low");

    // R10: status is empty in the cycle after reset
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (status_o == '0))
        else $error("status survived reset");

endmodule

// File: tb/test_gpio_irq_detector.sv
`timescale 1ns/1ps
module test_gpio_irq_detector;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [N-1:0]   pin;
    logic [3*N-1:0] cfg;
    logic [N-1:0]   en;
    logic [N-1:0]   clr;
    logic [N-1:0]   status;
    logic           irq;

    int    vectors = 0;
    int    errors  = 0;
    int    cycles  = 0;
    bit    done    = 0;
    string tag     = "R10";

    // Behavioural model state
    logic [N-1:0] m_prev = '0;
    logic [N-1:0] m_stat = '0;
    bit           m_hist = 0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_irq_detector #(.NUM_PINS(N)) i_gpio_irq_detector (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (pin),
        .trig_cfg_i (cfg),
        .irq_en_i   (en),
        .clr_i      (clr),
        .status_o   (status),
        .irq_o      (irq)
    );

    // Mode ids: 0 low level, 1 high level, 2 rising, 3 falling, 4 either edge
    function automatic logic [2:0] mode_code(input int m);
        case (m)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b011;
            3: return 3'b010;
            default: return 3'b110;
        endcase
    endfunction

    function automatic logic [3*N-1:0] put_mode(input logic [3*N-1:0] c, input int n, input int m);
        logic [2:0] k = mode_code(m);
        c[n]       = k[0];
        c[N + n]   = k[1];
        c[2*N + n] = k[2];
        return c;
    endfunction

    function automatic logic [3*N-1:0] all_mode(input int m);
        logic [3*N-1:0] c = '0;
        for (int n = 0; n < N; n++) c = put_mode(c, n, m);
        return c;
    endfunction

    task automatic step(input logic r, input logic [N-1:0] p, input logic [3*N-1:0] c,
                        input logic [N-1:0] e, input logic [N-1:0] k);
        logic [N-1:0] exp_stat;
        logic         exp_irq;
        rst = r; pin = p; cfg = c; en = e; clr = k;
        @(posedge clk);
        if (r) begin
            m_stat = '0;
            m_hist = 0;
        end else begin
            for (int n = 0; n < N; n++) begin
                bit pol  = c[n];
                bit edg  = c[N + n];
                bit both = c[2*N + n];
                bit ev;
                if (!edg)       ev = pol ? p[n] : !p[n];
                else if (!m_hist) ev = 0;
                else if (both)  ev = (p[n] != m_prev[n]);
                else if (pol)   ev = p[n] && !m_prev[n];
                else            ev = !p[n] && m_prev[n];
                m_stat[n] = ev | (m_stat[n] & ~k[n]);
            end
            m_hist = 1;
        end
        m_prev = p;
        @(negedge clk);
        exp_stat = m_stat;
        exp_irq  = |(m_stat & en);
        vectors++;
        if (status !== exp_stat) begin
            errors++;
            $display("FAIL %s: status_o=%h expected %h", tag, status, exp_stat);
        end
        vectors++;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: irq_o=%b expected %b", tag, irq, exp_irq);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1; pin = '0; cfg = '0; en = '0; clr = '0;
        @(negedge clk);

        // R10: reset holds status empty even with high levels present
        tag = "R10";
        repeat (3) step(1, 8'hFF, all_mode(1), 8'hFF, 8'h00);

        // R5: falling transition across reset release is not an edge
        tag = "R5";
        step(0, 8'h00, all_mode(3), 8'hFF, 8'h00);
        step(0, 8'hFF, all_mode(3), 8'hFF, 8'h00);
        tag = "R3";
        step(0, 8'h5A, all_mode(3), 8'hFF, 8'h00);
        step(0, 8'h5A, all_mode(3), 8'hFF, 8'hFF);

        // R3: rising mode, assorted patterns; R9 sticky afterwards
        step(0, 8'h00, all_mode(2), 8'hFF, 8'hFF);
        step(0, 8'h0F, all_mode(2), 8'hFF, 8'h00);
        tag = "R9";
        step(0, 8'h00, all_mode(2), 8'hFF, 8'h00);
        step(0, 8'h00, all_mode(2), 8'hFF, 8'h00);
        tag = "R3";
        step(0, 8'hC3, all_mode(2), 8'hFF, 8'h00);

        // R6: partial clear, zeros leave bits alone
        tag = "R6";
        step(0, 8'hC3, all_mode(2), 8'hFF, 8'h05);
        step(0, 8'hC3, all_mode(2), 8'hFF, 8'h00);
        step(0, 8'hC3, all_mode(2), 8'hFF, 8'hFF);

        // R4: either edge
        tag = "R4";
        step(0, 8'h3C, all_mode(4), 8'hFF, 8'h00);
        step(0, 8'h3C, all_mode(4), 8'hFF, 8'hFF);
        step(0, 8'h34, all_mode(4), 8'hFF, 8'h00);

        // R7: clear and rising edge in the same cycle
        tag = "R7";
        step(0, 8'h00, all_mode(2), 8'hFF, 8'hFF);
        step(0, 8'h00, all_mode(2), 8'hFF, 8'hFF);
        step(0, 8'h81, all_mode(2), 8'hFF, 8'hFF);
        step(0, 8'h81, all_mode(2), 8'hFF, 8'hFF);

        // R2: levels persist through repeated clears
        tag = "R2";
        step(0, 8'hF0, all_mode(1), 8'hFF, 8'hFF);
        step(0, 8'hF0, all_mode(1), 8'hFF, 8'hFF);
        step(0, 8'hF0, all_mode(0), 8'hFF, 8'hFF);
        step(0, 8'hF0, all_mode(0), 8'hFF, 8'hFF);

        // R8: latch with enable low, line follows enable
        tag = "R8";
        step(0, 8'h00, all_mode(2), 8'h00, 8'hFF);
        step(0, 8'h02, all_mode(2), 8'h00, 8'h00);
        step(0, 8'h02, all_mode(2), 8'h02, 8'h00);
        step(0, 8'h02, all_mode(2), 8'hFD, 8'h00);

        // R1: mixed per-pin fields, including ignored-bit variants
        tag = "R1";
        begin
            logic [3*N-1:0] c = '0;
            for (int n = 0; n < N; n++) c = put_mode(c, n, n % 5);
            c[2*N + 0] = 1'b1;          // both bit ignored in level mode
            c[4]       = 1'b1;          // polarity ignored in either-edge mode
            step(0, 8'h00, c, 8'hFF, 8'hFF);
            step(0, 8'hFF, c, 8'hFF, 8'h00);
            step(0, 8'h00, c, 8'hFF, 8'hFF);
            step(0, 8'hA5, c, 8'hFF, 8'h00);
        end

        // R1: random stretch over mixed modes and sparse clears
        for (int i = 0; i < 3000; i++) begin
            logic [3*N-1:0] c = '0;
            logic [N-1:0]   k;
            for (int n = 0; n < N; n++) c = put_mode(c, n, int'($urandom % 5));
            if (i % 50 == 0) c = $urandom;
            k = (($urandom % 4) == 0) ? N'($urandom) : '0;
            step((i % 997) == 500, N'($urandom), c, N'($urandom), k);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule